// File: doc/BRIEF.md
# Frame-Aligned Shadow Configuration Bank

This block holds the configuration words of an image sensor's timing controller. Each word is kept twice. The host register port reads and writes the pending copy. The live copy drives the timing logic. Synchronized bits move from pending to live only on a frame-start strobe. A frame start is the moment the first dark row is read out. By default it comes six row times before frame-valid rises, and showing dark rows in the image does not move it. Bits that are not synchronized follow a host write at once.

A hold bit lets software stage a batch of writes with no transfer, then release them all at the next frame start. After every transfer the block says which registers' synchronized bits actually changed. A downstream masking stage uses that pulse to suppress the frame that was integrated with the old settings.

A two-state controller governs transfers. In `XF_OPEN` a frame-start strobe copies pending to live. In `XF_HELD` the strobe is ignored. A host write to the hold bit moves the controller: writing 1 takes `XF_OPEN -> XF_HELD`, and writing 0 takes `XF_HELD -> XF_OPEN`. Otherwise the controller stays in its state.

Top module: `frame_shadow_bank`

## Requirements
- R1: A write stores `wr_data`, ANDed with the register's implemented-bit mask, into pending register `wr_addr`. `rd_data` shows that pending register combinationally, with unimplemented bits reading 0. Implemented masks: register 0 is 0x00FF, register 5 is 0x07FF, register 13 is 0x800F, and all other registers are 0xFFFF. Addresses 14 and 15 read 0.
- R2: Synchronized live bits never change on a clock edge that is not a transfer. Register 13 and register 12 have no synchronized bits. Register 3 synchronizes only bits 15:8. Every other register synchronizes all of its implemented bits.
- R3: A transfer happens on a rising edge where `frame_start` is 1 and the controller is in `XF_OPEN`. On that edge the synchronized live bits take the pending values held before the edge, so a write on the same edge is not included.
- R4: The hold bit is bit 15 of register 13. A write sets the controller state from the next edge onward. While the controller is held, `frame_start` changes no live value and raises no pulse.
- R5: Unsynchronized implemented bits of live take the written value on the edge of the write.
- R6: The cycle after a transfer, `xfer_fields[i]` is 1 exactly when register i's synchronized bits changed. `xfer_pulse` is the OR of those bits. Both are 0 in every other cycle.
- R7: Reset is asynchronous and active low. It loads both copies of register i with (0x0101·i + 0x0040) masked by the implemented mask. Register 13 resets to 0, so the controller starts in `XF_OPEN`. The pulse outputs reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 16 | Pending value at `rd_addr` |
| frame_start | input | 1 | One-cycle frame-start strobe |
| live_flat | output | 224 | Live copies; register i is at bits i*16+15 : i*16 |
| xfer_pulse | output | 1 | Transfer changed at least one live value |
| xfer_fields | output | 14 | Per-register change flags of the last transfer |

## Verification
A corrupted pending copy shows up on `rd_data` in the same cycle as the read. It also shows up in the live outputs right after the next unheld frame start. A live copy that drifts between transfers shows at `live_flat` on the very next clock, because the reference model compares every register on every cycle. A controller stuck in the wrong state gives one of two symptoms. Either a transfer is missed, so live and the pulse lag the model by a frame, or a transfer is not blocked, so live moves while held. Both appear one cycle after the first strobe that the wrong state handles.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    localparam int REGS = 14;
    localparam int DW   = 16;
    localparam int AW   = 4;

    typedef enum logic {
        XF_OPEN = 1'b0,
        XF_HELD = 1'b1
    } xfer_state_e;

    function automatic logic [DW-1:0] impl_of(input int idx);
        unique case (idx)
            0:       return 16'h00FF;
            5:       return 16'h07FF;
            13:      return 16'h800F;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [DW-1:0] sync_of(input int idx);
        unique case (idx)
            3:       return 16'hFF00;
            12, 13:  return 16'h0000;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [DW-1:0] reset_of(input int idx);
        logic [DW-1:0] base;
        base = DW'(idx) * 16'h0101 + 16'h0040;
        if (idx == 13) begin
            base = '0;
        end
        return base & impl_of(idx);
    endfunction

    function automatic logic [REGS*DW-1:0] impl_table();
        logic [REGS*DW-1:0] v;
        for (int i = 0; i < REGS; i++) v[i*DW +: DW] = impl_of(i);
        return v;
    endfunction

    function automatic logic [REGS*DW-1:0] sync_table();
        logic [REGS*DW-1:0] v;
        for (int i = 0; i < REGS; i++) v[i*DW +: DW] = sync_of(i);
        return v;
    endfunction

    function automatic logic [REGS*DW-1:0] reset_table();
        logic [REGS*DW-1:0] v;
        for (int i = 0; i < REGS; i++) v[i*DW +: DW] = reset_of(i);
        return v;
    endfunction

endpackage

// File: rtl/fsb_slot.sv
module fsb_slot #(
    parameter int              W     = 16,
    parameter logic [W-1:0]    RST   = '0,
    parameter logic [W-1:0]    SYNC  = '1,
    parameter logic [W-1:0]    IMPL  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    input  logic         do_xfer,
    output logic [W-1:0] pend,
    output logic [W-1:0] live,
    output logic         changed
);

    localparam logic [W-1:0] SYNC_EFF = SYNC & IMPL;
    localparam logic [W-1:0] DIRECT   = IMPL & ~SYNC;

    logic [W-1:0] live_next;
    logic         changed_next;

    always_comb begin
        live_next = live;
        if (do_xfer) begin
            live_next = (live_next & ~SYNC_EFF) | (pend & SYNC_EFF);
        end
        if (wr_hit) begin
            live_next = (live_next & ~DIRECT) | (wr_data & DIRECT);
        end
        changed_next = do_xfer && (|((pend ^ live) & SYNC_EFF));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= RST;
            live    <= RST;
            changed <= 1'b0;
        end else begin
            if (wr_hit) begin
                pend <= wr_data & IMPL;
            end
            live    <= live_next;
            changed <= changed_next;
        end
    end

    assert_sync_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !do_xfer |=> ((live & SYNC_EFF) == $past(live & SYNC_EFF)));

    assert_xfer_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_xfer |=> ((live & SYNC_EFF) == $past(pend & SYNC_EFF)));

    assert_direct_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((live & DIRECT) == $past(wr_data & DIRECT)));

endmodule

// File: rtl/fsb_xfer_ctl.sv
module fsb_xfer_ctl
    import fsb_pkg::*;
#(
    parameter logic RST_HOLD = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_hold_val,
    input  logic frame_start,
    output logic do_xfer,
    output logic hold_on
);

    localparam xfer_state_e RST_STATE = RST_HOLD ? XF_HELD : XF_OPEN;

    xfer_state_e state_q;
    xfer_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_OPEN: if (ctrl_wr && ctrl_hold_val)  state_d = XF_HELD;
            XF_HELD: if (ctrl_wr && !ctrl_hold_val) state_d = XF_OPEN;
            default: state_d = XF_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        do_xfer = 1'b0;
        hold_on = 1'b0;
        unique case (state_q)
            XF_OPEN: do_xfer = frame_start;
            XF_HELD: hold_on = 1'b1;
            default: ;
        endcase
    end

    assert_hold_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (hold_on == $past(ctrl_hold_val)));

endmodule

// File: rtl/fsb_rd_mux.sv
module fsb_rd_mux #(
    parameter int NUM_REGS = 14,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4
) (
    input  logic [NUM_REGS*DATA_W-1:0] pend_flat,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data
);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = pend_flat[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/frame_shadow_bank.sv
module frame_shadow_bank
    import fsb_pkg::*;
#(
    parameter int NUM_REGS = fsb_pkg::REGS,
    parameter int DATA_W   = fsb_pkg::DW,
    parameter int ADDR_W   = fsb_pkg::AW,
    parameter int HOLD_IDX = 13,
    parameter int HOLD_BIT = 15,
    parameter logic [NUM_REGS*DATA_W-1:0] IMPL_VEC = fsb_pkg::impl_table(),
    parameter logic [NUM_REGS*DATA_W-1:0] SYNC_VEC = fsb_pkg::sync_table(),
    parameter logic [NUM_REGS*DATA_W-1:0] RST_VEC  = fsb_pkg::reset_table()
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    input  logic                       frame_start,
    output logic [NUM_REGS*DATA_W-1:0] live_flat,
    output logic                       xfer_pulse,
    output logic [NUM_REGS-1:0]        xfer_fields
);

    localparam logic RST_HOLD = RST_VEC[HOLD_IDX*DATA_W + HOLD_BIT];

    logic                       do_xfer;
    logic                       hold_on;
    logic                       ctrl_wr;
    logic [NUM_REGS-1:0]        wr_hit;
    logic [NUM_REGS*DATA_W-1:0] pend_flat;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
        end
    end

    assign ctrl_wr = wr_hit[HOLD_IDX];

    fsb_xfer_ctl #(
        .RST_HOLD (RST_HOLD)
    ) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_wr       (ctrl_wr),
        .ctrl_hold_val (wr_data[HOLD_BIT]),
        .frame_start   (frame_start),
        .do_xfer       (do_xfer),
        .hold_on       (hold_on)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        fsb_slot #(
            .W    (DATA_W),
            .RST  (RST_VEC [g*DATA_W +: DATA_W]),
            .SYNC (SYNC_VEC[g*DATA_W +: DATA_W]),
            .IMPL (IMPL_VEC[g*DATA_W +: DATA_W])
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit[g]),
            .wr_data (wr_data),
            .do_xfer (do_xfer),
            .pend    (pend_flat[g*DATA_W +: DATA_W]),
            .live    (live_flat[g*DATA_W +: DATA_W]),
            .changed (xfer_fields[g])
        );
    end

    assign xfer_pulse = |xfer_fields;

    fsb_rd_mux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_rd (
        .pend_flat (pend_flat),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    logic [DATA_W-1:0] impl_sel;
    always_comb begin
        impl_sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) impl_sel = IMPL_VEC[i*DATA_W +: DATA_W];
        end
    end

    assert_unimpl_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & ~impl_sel) == '0));

    assert_pulse_needs_open_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_pulse |-> ($past(frame_start) && !$past(hold_on)));

    assert_held_strobe_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_on && frame_start) |=> !xfer_pulse);

endmodule

// File: tb/frame_shadow_bank_bench.sv
module frame_shadow_bank_bench;

    localparam int N  = 14;
    localparam int W  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [W-1:0]   wr_data = '0;
    logic [3:0]     rd_addr = '0;
    logic [W-1:0]   rd_data;
    logic           frame_start = 1'b0;
    logic [N*W-1:0] live_flat;
    logic           xfer_pulse;
    logic [N-1:0]   xfer_fields;

    int checks = 0;
    int errors = 0;
    bit armed  = 1'b0;

    always #2 clk = ~clk;

    frame_shadow_bank u_frame_shadow_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .frame_start (frame_start),
        .live_flat   (live_flat),
        .xfer_pulse  (xfer_pulse),
        .xfer_fields (xfer_fields)
    );

    // Specification tables (R1, R2, R7)
    function automatic logic [W-1:0] b_impl(input int r);
        if (r == 0)  return 16'h00FF;
        if (r == 5)  return 16'h07FF;
        if (r == 13) return 16'h800F;
        return 16'hFFFF;
    endfunction

    function automatic logic [W-1:0] b_sync(input int r);
        if (r == 12 || r == 13) return 16'h0000;
        if (r == 3) return 16'hFF00;
        return 16'hFFFF & b_impl(r);
    endfunction

    function automatic logic [W-1:0] b_rst(input int r);
        if (r == 13) return 16'h0000;
        return (16'h0101 * r[15:0] + 16'h0040) & b_impl(r);
    endfunction

    // Behavioural reference model
    logic [W-1:0] m_pend [N];
    logic [W-1:0] m_live [N];
    logic [N-1:0] m_fields;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) begin
                m_pend[r] = b_rst(r);
                m_live[r] = b_rst(r);
            end
            m_fields = '0;
            armed = 1'b1;
        end else begin
            bit go;
            go = frame_start && !m_pend[13][15];
            m_fields = '0;
            if (go) begin
                for (int r = 0; r < N; r++) begin
                    if (((m_pend[r] ^ m_live[r]) & b_sync(r)) != 0) m_fields[r] = 1'b1;
                    m_live[r] = (m_live[r] & ~b_sync(r)) | (m_pend[r] & b_sync(r));
                end
            end
            if (wr_en && wr_addr < N) begin
                m_pend[wr_addr] = wr_data & b_impl(int'(wr_addr));
                m_live[wr_addr] = (m_live[wr_addr] & ~(b_impl(int'(wr_addr)) & ~b_sync(int'(wr_addr))))
                                | (wr_data & b_impl(int'(wr_addr)) & ~b_sync(int'(wr_addr)));
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (armed) begin
            for (int r = 0; r < N; r++) begin
                checks++;
                if (live_flat[r*W +: W] !== m_live[r]) begin
                    errors++;
                    $display("FAIL R3 live reg %0d: actual %h expected %h", r, live_flat[r*W +: W], m_live[r]);
                end
            end
            checks++;
            if (xfer_fields !== m_fields) begin
                errors++;
                $display("FAIL R6 fields: actual %b expected %b", xfer_fields, m_fields);
            end
            checks++;
            if (xfer_pulse !== (|m_fields)) begin
                errors++;
                $display("FAIL R6 pulse: actual %b expected %b", xfer_pulse, |m_fields);
            end
            checks++;
            if (rd_data !== ((rd_addr < N) ? m_pend[rd_addr] : 16'h0000)) begin
                errors++;
                $display("FAIL R1 read addr %0d: actual %h expected %h", rd_addr, rd_data,
                         (rd_addr < N) ? m_pend[rd_addr] : 16'h0000);
            end
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input bit we, input int a, input logic [W-1:0] d, input bit fs);
        @(posedge clk);
        #1;
        wr_en = we; wr_addr = 4'(a); wr_data = d; frame_start = fs;
    endtask

    task automatic idle();
        step(1'b0, 0, 16'h0000, 1'b0);
    endtask

    function automatic logic [W-1:0] lv(input int r);
        return live_flat[r*W +: W];
    endfunction

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset live reg1", lv(1), 16'h0141);
        chk("R7 reset live reg13", lv(13), 16'h0000);
        chk("R7 reset pulse", {15'd0, xfer_pulse}, 16'h0000);

        // Pending write is not live until a transfer
        step(1'b1, 1, 16'hBEEF, 1'b0); idle();
        rd_addr = 4'd1;
        @(negedge clk);
        chk("R2 live reg1 before transfer", lv(1), 16'h0141);
        chk("R1 pending readback reg1", rd_data, 16'hBEEF);
        step(1'b0, 0, 0, 1'b1); idle();
        @(negedge clk);
        chk("R3 live reg1 after transfer", lv(1), 16'hBEEF);
        chk("R6 pulse after changing transfer", {15'd0, xfer_pulse}, 16'h0001);
        idle(); @(negedge clk);
        chk("R6 pulse lasts one cycle", {15'd0, xfer_pulse}, 16'h0000);
        step(1'b0, 0, 0, 1'b1); idle(); @(negedge clk);
        chk("R6 no pulse on unchanged transfer", {15'd0, xfer_pulse}, 16'h0000);

        // Hold batches writes
        step(1'b1, 13, 16'h8000, 1'b0);
        step(1'b1, 2, 16'h1234, 1'b0);
        step(1'b1, 6, 16'h5678, 1'b0);
        step(1'b0, 0, 0, 1'b1); idle(); @(negedge clk);
        chk("R4 held reg2", lv(2), 16'h0242);
        chk("R4 held reg6", lv(6), 16'h0646);
        chk("R4 held no pulse", {15'd0, xfer_pulse}, 16'h0000);
        step(1'b1, 13, 16'h0000, 1'b0);
        step(1'b0, 0, 0, 1'b1); idle(); @(negedge clk);
        chk("R4 released reg2", lv(2), 16'h1234);
        chk("R4 released reg6", lv(6), 16'h5678);
        chk("R6 released fields", {2'b00, xfer_fields}, 16'h0044);

        // Unsynchronized and mixed registers
        step(1'b1, 12, 16'hA5A5, 1'b0); idle(); @(negedge clk);
        chk("R5 reg12 immediate", lv(12), 16'hA5A5);
        step(1'b1, 3, 16'hABCD, 1'b0); idle(); @(negedge clk);
        chk("R5 reg3 low byte immediate", lv(3), 16'h03CD);
        step(1'b0, 0, 0, 1'b1); idle(); @(negedge clk);
        chk("R3 reg3 high byte at transfer", lv(3), 16'hABCD);

        // Unimplemented bits and addresses
        step(1'b1, 0, 16'hFFFF, 1'b0); idle();
        rd_addr = 4'd0; @(negedge clk);
        chk("R1 reg0 upper bits read zero", rd_data, 16'h00FF);
        rd_addr = 4'd14; @(negedge clk);
        chk("R1 address 14 reads zero", rd_data, 16'h0000);

        // Write on the transfer edge is not included
        step(1'b1, 4, 16'h7777, 1'b1); idle(); @(negedge clk);
        chk("R3 same-edge write excluded", lv(4), 16'h0444);
        step(1'b0, 0, 0, 1'b1); idle(); @(negedge clk);
        chk("R3 next transfer applies", lv(4), 16'h7777);

        // Hold set on the strobe edge does not block that strobe
        step(1'b1, 7, 16'h0F0F, 1'b0);
        step(1'b1, 13, 16'h8000, 1'b1); idle(); @(negedge clk);
        chk("R4 hold takes effect next edge", lv(7), 16'h0F0F);
        step(1'b1, 13, 16'h0000, 1'b0); idle();

        // Pseudo-random traffic checked against the model
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_addr = lfsr[7:4];
            step(lfsr[0], int'(lfsr[11:8]), {lfsr[3:0], lfsr[15:4]}, lfsr[1] & lfsr[2]);
        end
        idle(); idle();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule